// File: doc/BRIEF.md
# Dual-Slope Waveform Core

This block is the digital heart of a function generator. A phase accumulator climbs at one programmable rate and descends at a second, independent rate. One sweep up and one sweep down form one period, so the two 12-bit rate words set the frequency and the duty cycle together. From that phase the block produces three outputs:
- a signed triangle or square sample;
- a square-phase indicator;
- a one-cycle sync pulse, in both polarities.

A clock-enable `tick`, derived from the selected frequency range, paces every step.

Software starts the waveform by raising `out_en` with a waveform function selected. The waveform always starts at its lowest point. When `out_en` is dropped, the block does one of two things. With `sync_stop_en` low it returns to zero immediately. With `sync_stop_en` high it first completes the cycle in progress and then returns to zero. A DC function holds the waveform contribution at zero, so only a downstream offset path would drive the output.

Top module: `dual_slope_wave_core`

## Requirements
- R1: After reset:
  - `sample` is 0 and `square_out` is 0.
  - `sync_hi` is 0 and `sync_lo` is 1.
  - The waveform is idle.
- R2: On the first clock edge where `out_en` is 1 and a waveform function is selected, the waveform starts at its lowest point: phase 0, rising. In triangle mode the sample is then -2048.
- R3: While rising, each tick adds `rate_up` to the phase. When the sum reaches or exceeds 4095, the phase is clamped to 4095 and the direction turns to falling.
- R4: While falling, each tick subtracts `rate_dn` from the phase. When the phase is at or below `rate_dn`, it is clamped to 0 and the direction turns to rising.
- R5: With ticks on every clock, the waveform spends ceil(4095/`rate_up`) cycles rising and ceil(4095/`rate_dn`) cycles falling. Equal words therefore give a 50% duty cycle.
- R6: A rate word of 0 holds the phase steady in its current direction.
- R7: The sample depends on the function:
  - Triangle mode gives phase minus 2048.
  - Square mode gives +2047 while rising and -2048 while falling.
  - `square_out` is 1 exactly while a waveform is running and rising.
- R8: In triangle mode (`func_sel` = 2'b10), `sync_hi` pulses high for exactly one clock after each tick that returns the phase to 0. `sync_lo` is always its complement.
- R9: In square mode (`func_sel` = 2'b11), the sync pulse follows the tick on which the rising phase turns to falling, that is, the falling edge of the square.
- R10: If `out_en` drops while `sync_stop_en` is 1, the waveform continues until the tick that returns the phase to 0. At that point it stops and the sample becomes 0.
- R11: If `out_en` drops while `sync_stop_en` is 0, the waveform stops on the next clock edge, and `sample` and `square_out` become 0.
- R12: Function codes 2'b00 (DC) and 2'b01 (reserved) keep `sample` and `square_out` at 0 and emit no sync pulse, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Step enable from the range divider |
| func_sel | input | 2 | Function: 00 DC, 01 reserved (DC), 10 triangle, 11 square |
| out_en | input | 1 | Output enable |
| sync_stop_en | input | 1 | 1: finish the current cycle on disable; 0: stop at once |
| rate_up | input | PHASE_W | Rising-slope rate word |
| rate_dn | input | PHASE_W | Falling-slope rate word |
| sample | output | PHASE_W | Signed waveform sample |
| square_out | output | 1 | High during the rising phase of a running waveform |
| sync_hi | output | 1 | High-true sync pulse |
| sync_lo | output | 1 | Low-true sync pulse |

## Verification
Several properties are checked on every cycle:
- the phase never moves against its direction;
- the phase holds when no step is taken;
- the sync pulse never lasts more than one clock;
- an idle core drives zero;
- an immediate disable or a DC selection stops the engine;
- every start begins at phase 0, rising.

The bench covers what a single-cycle property cannot see:
- the exact arithmetic values, including the clamp points, checked over a sweep of rate pairs with both one-cycle and sparse ticks;
- the duty-cycle lengths counted over whole periods;
- the number of cycles a synchronous stop runs before it lands on zero.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

   typedef enum logic [1:0] {
      FN_DC  = 2'b00,
      FN_RSV = 2'b01,
      FN_TRI = 2'b10,
      FN_SQR = 2'b11
   } wave_fn_e;

   // A function drives a waveform only when its upper bit is set.
   function automatic logic fn_is_wave(input wave_fn_e fn);
      return fn[1];
   endfunction

endpackage

// File: rtl/dsw_slope_engine.sv
module dsw_slope_engine #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clear,
   input  logic [W-1:0] rate_up,
   input  logic [W-1:0] rate_dn,
   output logic [W-1:0] phase,
   output logic         rising,
   output logic         hit_peak,
   output logic         hit_floor
);
   localparam logic [W-1:0] TOP = '1;

   if (W < 4) begin : g_width_chk
      $error("dsw_slope_engine: W must be at least 4");
   end

   logic [W:0] up_sum;

   always_comb begin
      up_sum    = {1'b0, phase} + {1'b0, rate_up};
      hit_peak  = rising && (up_sum >= {1'b0, TOP});
      hit_floor = !rising && (phase <= rate_dn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= '0;
         rising <= 1'b1;
      end else if (clear) begin
         phase  <= '0;
         rising <= 1'b1;
      end else if (step) begin
         if (rising) begin
            if (hit_peak) begin
               phase  <= TOP;
               rising <= 1'b0;
            end else begin
               phase  <= up_sum[W-1:0];
            end
         end else begin
            if (hit_floor) begin
               phase  <= '0;
               rising <= 1'b1;
            end else begin
               phase  <= phase - rate_dn;
            end
         end
      end
   end

   // R3: a rising step never lowers the phase
   p_rise_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && rising && !clear) |=> (phase >= $past(phase)));

   // R4: a falling step never raises the phase
   p_fall_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !rising && !clear) |=> (phase <= $past(phase)));

   // R6: without a step or a clear the phase and the direction hold
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> ($stable(phase) && $stable(rising)));

endmodule

// File: rtl/dsw_run_ctrl.sv
module dsw_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic out_en,
   input  logic sync_stop_en,
   input  logic wave_on,
   input  logic floor_evt,
   output logic running,
   output logic clear
);
   logic run_nxt;

   always_comb begin
      if (!wave_on)
         run_nxt = 1'b0;
      else if (!running)
         run_nxt = out_en;
      else if (!out_en && !sync_stop_en)
         run_nxt = 1'b0;
      else if (!out_en && floor_evt)
         run_nxt = 1'b0;
      else
         run_nxt = 1'b1;
      clear = !run_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         running <= 1'b0;
      else
         running <= run_nxt;
   end

   // R11: an immediate disable stops the engine on the next edge
   p_imm_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (running && wave_on && !out_en && !sync_stop_en) |=> !running);

   // R10: a synchronous disable keeps running until the floor is reached
   p_sync_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && wave_on && !out_en && sync_stop_en && !floor_evt) |=> running);

   // R12: a DC or reserved function keeps the engine idle
   p_dc_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wave_on |=> !running);

endmodule

// File: rtl/dsw_out_stage.sv
module dsw_out_stage
   import dsw_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wave_fn_e     fn,
   input  logic         running,
   input  logic [W-1:0] phase,
   input  logic         rising,
   input  logic         peak_evt,
   input  logic         floor_evt,
   output logic [W-1:0] sample,
   output logic         square_out,
   output logic         sync_hi,
   output logic         sync_lo
);
   localparam logic [W-1:0] HI_LVL = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] LO_LVL = {1'b1, {(W-1){1'b0}}};

   logic sync_q;

   always_comb begin
      sample = '0;
      if (running) begin
         case (fn)
            FN_TRI:  sample = {~phase[W-1], phase[W-2:0]};
            FN_SQR:  sample = rising ? HI_LVL : LO_LVL;
            default: sample = '0;
         endcase
      end
      square_out = running && rising && fn_is_wave(fn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sync_q <= 1'b0;
      else
         sync_q <= ((fn == FN_TRI) && floor_evt) || ((fn == FN_SQR) && peak_evt);
   end

   assign sync_hi = sync_q;
   assign sync_lo = ~sync_q;

   // R8: the sync pulse is never wider than one clock
   p_sync_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |=> !sync_q);

   // R1: an idle core drives a zero sample and a low square
   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (sample == '0 && !square_out));

endmodule

// File: rtl/dual_slope_wave_core.sv
module dual_slope_wave_core
   import dsw_pkg::*;
#(
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [1:0]         func_sel,
   input  logic               out_en,
   input  logic               sync_stop_en,
   input  logic [PHASE_W-1:0] rate_up,
   input  logic [PHASE_W-1:0] rate_dn,
   output logic [PHASE_W-1:0] sample,
   output logic               square_out,
   output logic               sync_hi,
   output logic               sync_lo
);
   wave_fn_e           fn;
   logic               running;
   logic               clear;
   logic               step;
   logic [PHASE_W-1:0] phase;
   logic               rising;
   logic               hit_peak;
   logic               hit_floor;
   logic               peak_evt;
   logic               floor_evt;

   assign fn        = wave_fn_e'(func_sel);
   assign step      = tick && running;
   assign peak_evt  = step && hit_peak;
   assign floor_evt = step && hit_floor;

   dsw_run_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .out_en       (out_en),
      .sync_stop_en (sync_stop_en),
      .wave_on      (fn_is_wave(fn)),
      .floor_evt    (floor_evt),
      .running      (running),
      .clear        (clear)
   );

   dsw_slope_engine #(.W(PHASE_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .clear     (clear),
      .rate_up   (rate_up),
      .rate_dn   (rate_dn),
      .phase     (phase),
      .rising    (rising),
      .hit_peak  (hit_peak),
      .hit_floor (hit_floor)
   );

   dsw_out_stage #(.W(PHASE_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .fn         (fn),
      .running    (running),
      .phase      (phase),
      .rising     (rising),
      .peak_evt   (peak_evt),
      .floor_evt  (floor_evt),
      .sample     (sample),
      .square_out (square_out),
      .sync_hi    (sync_hi),
      .sync_lo    (sync_lo)
   );

   // R2: every start of the engine begins at the lowest point, rising
   p_start_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (phase == '0 && rising));

endmodule

// File: tb/dual_slope_wave_core_tb.sv
`timescale 1ns/1ps
module dual_slope_wave_core_tb;
   localparam int W   = 12;
   localparam int TOP = 4095;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [1:0]   func_sel = 2'b00;
   logic         out_en = 1'b0;
   logic         sync_stop_en = 1'b0;
   logic [W-1:0] rate_up = '0;
   logic [W-1:0] rate_dn = '0;
   logic signed [W-1:0] sample;
   logic         square_out, sync_hi, sync_lo;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference state computed from the requirements
   bit m_run = 0;
   int m_phase = 0;
   bit m_rise = 1;
   bit m_sync = 0;

   always #2 clk = ~clk;

   dual_slope_wave_core #(.PHASE_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .func_sel(func_sel),
      .out_en(out_en), .sync_stop_en(sync_stop_en),
      .rate_up(rate_up), .rate_dn(rate_dn),
      .sample(sample), .square_out(square_out),
      .sync_hi(sync_hi), .sync_lo(sync_lo)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_sample();
      if (!m_run || !func_sel[1]) return 0;
      if (func_sel == 2'b10) return m_phase - 2048;
      return m_rise ? 2047 : -2048;
   endfunction

   // R3/R4/R10/R11/R12 rules applied to one clock edge
   task automatic model_edge();
      bit stp, pk, fl, nrun;
      stp = tick && m_run;
      pk  = m_rise && (m_phase + int'(rate_up) >= TOP);
      fl  = !m_rise && (m_phase <= int'(rate_dn));
      m_sync = stp && ((func_sel == 2'b10 && fl) || (func_sel == 2'b11 && pk));
      if (!func_sel[1]) nrun = 0;
      else if (!m_run) nrun = out_en;
      else if (!out_en && (!sync_stop_en || (stp && fl))) nrun = 0;
      else nrun = 1;
      if (!nrun) begin
         m_phase = 0; m_rise = 1;
      end else if (stp) begin
         if (m_rise) begin
            if (pk) begin m_phase = TOP; m_rise = 0; end
            else m_phase = m_phase + int'(rate_up);
         end else begin
            if (fl) begin m_phase = 0; m_rise = 1; end
            else m_phase = m_phase - int'(rate_dn);
         end
      end
      m_run = nrun;
   endtask

   task automatic cyc(input string tag, input bit tk);
      tick = tk;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(tag, "sample", int'(sample), exp_sample());
      chk(tag, "square_out", int'(square_out), int'(m_run && m_rise && func_sel[1]));
      chk(tag, "sync_hi", int'(sync_hi), int'(m_sync));
      chk(tag, "sync_lo", int'(sync_lo), int'(!m_sync));
   endtask

   task automatic halt();
      out_en = 0; sync_stop_en = 0;
      cyc("R11", 1'b0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      int hi_cnt, lo_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "sample", int'(sample), 0);
      chk("R1", "square_out", int'(square_out), 0);
      chk("R1", "sync_hi", int'(sync_hi), 0);
      chk("R1", "sync_lo", int'(sync_lo), 1);

      // R2 start at lowest point
      func_sel = 2'b10; rate_up = 12'd1000; rate_dn = 12'd1000; out_en = 1;
      cyc("R2", 1'b0);
      chk("R2", "start sample", int'(sample), -2048);
      chk("R2", "start square", int'(square_out), 1);
      // R3 rising steps and clamp
      cyc("R3", 1'b1);
      chk("R3", "one step", int'(sample), -1048);
      repeat (3) cyc("R3", 1'b1);
      chk("R3", "four steps", int'(sample), 4000 - 2048);
      cyc("R3", 1'b1);
      chk("R3", "clamp top", int'(sample), 2047);
      chk("R3", "turned falling", int'(square_out), 0);
      // R4 falling steps and clamp, R8 sync at the floor
      repeat (4) cyc("R4", 1'b1);
      chk("R4", "four down", int'(sample), 95 - 2048);
      cyc("R4", 1'b1);
      chk("R4", "clamp floor", int'(sample), -2048);
      chk("R8", "sync at floor", int'(sync_hi), 1);
      chk("R8", "sync_lo at floor", int'(sync_lo), 0);
      cyc("R8", 1'b1);
      chk("R8", "sync width", int'(sync_hi), 0);
      halt();

      // R5 duty cycle lengths
      for (int k = 0; k < 3; k++) begin
         int up, dn;
         up = (k == 0) ? 512 : (k == 1) ? 1024 : 300;
         dn = (k == 0) ? 512 : (k == 1) ? 256 : 2000;
         rate_up = up[W-1:0]; rate_dn = dn[W-1:0];
         func_sel = 2'b11; out_en = 1;
         cyc("R5", 1'b1);
         hi_cnt = 0; lo_cnt = 0;
         while (square_out && hi_cnt < 5000) begin hi_cnt++; cyc("R5", 1'b1); end
         while (!square_out && lo_cnt < 5000) begin lo_cnt++; cyc("R5", 1'b1); end
         chk("R5", "rising cycles", hi_cnt, (TOP + up - 1) / up);
         chk("R5", "falling cycles", lo_cnt, (TOP + dn - 1) / dn);
         halt();
      end

      // R6 zero rate holds
      func_sel = 2'b10; rate_up = 0; rate_dn = 0; out_en = 1;
      cyc("R6", 1'b1);
      repeat (20) cyc("R6", 1'b1);
      chk("R6", "hold rising", int'(sample), -2048);
      rate_up = 12'd4095;
      cyc("R6", 1'b1);
      rate_up = 0;
      repeat (10) cyc("R6", 1'b1);
      chk("R6", "hold falling", int'(sample), 2047);
      halt();

      // R7 / R9 square mode levels and sync at the falling edge
      func_sel = 2'b11; rate_up = 12'd2048; rate_dn = 12'd2048; out_en = 1;
      cyc("R7", 1'b0);
      chk("R7", "square high", int'(sample), 2047);
      cyc("R7", 1'b1);
      chk("R9", "no sync yet", int'(sync_hi), 0);
      cyc("R9", 1'b1);
      chk("R7", "square low", int'(sample), -2048);
      chk("R9", "sync at fall", int'(sync_hi), 1);
      cyc("R9", 1'b1);
      cyc("R9", 1'b1);
      chk("R9", "no sync at floor", int'(sync_hi), 0);
      halt();

      // R10 synchronous stop
      func_sel = 2'b10; rate_up = 12'd1000; rate_dn = 12'd1000; out_en = 1;
      cyc("R10", 1'b0);
      repeat (2) cyc("R10", 1'b1);
      out_en = 0; sync_stop_en = 1;
      repeat (7) cyc("R10", 1'b1);
      chk("R10", "still running", int'(sample), 95 - 2048);
      cyc("R10", 1'b1);
      chk("R10", "stopped at floor", int'(sample), 0);
      repeat (3) cyc("R10", 1'b1);
      chk("R10", "stays stopped", int'(sample), 0);
      halt();

      // R11 immediate stop
      out_en = 1;
      cyc("R11", 1'b0);
      repeat (2) cyc("R11", 1'b1);
      out_en = 0; sync_stop_en = 0;
      cyc("R11", 1'b1);
      chk("R11", "zero at once", int'(sample), 0);
      chk("R11", "square low", int'(square_out), 0);

      // R12 DC and reserved codes
      for (int f = 0; f < 2; f++) begin
         func_sel = f[1:0]; out_en = 1; rate_up = 12'd4095; rate_dn = 12'd4095;
         for (int i = 0; i < 8; i++) begin
            cyc("R12", 1'b1);
            chk("R12", "dc sample", int'(sample), 0);
            chk("R12", "dc sync", int'(sync_hi), 0);
         end
      end
      halt();

      // sweep of rate pairs in both waveform modes (R3, R4, R7, R8, R9)
      for (int fm = 2; fm < 4; fm++) begin
         for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
               int up, dn, len, td;
               up = (a == 0) ? 4095 : (a == 1) ? 2000 : (a == 2) ? 819 : (a == 3) ? 257 : 64;
               dn = (b == 0) ? 4095 : (b == 1) ? 2000 : (b == 2) ? 819 : (b == 3) ? 257 : 64;
               td = (fm == 2 && b[0]) ? 3 : 1;
               len = td * 2 * ((TOP + up - 1) / up + (TOP + dn - 1) / dn) + 4;
               rate_up = up[W-1:0]; rate_dn = dn[W-1:0];
               func_sel = fm[1:0]; out_en = 1;
               for (int c = 0; c < len; c++)
                  cyc(fm == 2 ? "R8" : "R9", (c % td) == 0);
               halt();
            end
         end
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule